// File: doc/BRIEF.md
# In-Order Completion Buffer with Precise Flush

This block tracks instructions from the moment they are dispatched until they leave the machine, and keeps them in program order. Each dispatched instruction receives a slot in a circular buffer. The slot index doubles as the instruction's rename tag. Execution units may finish in any order. A finishing unit names the tag, supplies the result, and raises an exception flag if the instruction faulted. The result stays in the slot, which acts as its rename register, until the instruction becomes the oldest one still in flight.

Retirement walks the buffer from the oldest slot. At most two instructions leave per cycle, and a finished instruction never passes an older unfinished one. Each retirement presents the result, the destination register number and a file select (integer or floating-point) to the architectural register files. A fault reported by an execution unit stays silent until the faulting instruction is the oldest in the buffer. In that cycle the block drives a one-cycle redirect carrying the faulting instruction's program counter and tag. It also blocks dispatch and discards every entry. The faulting result is never written back, and all younger results are dropped with it. The next dispatch reuses the faulting instruction's slot.

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `rt_valid` is 0 and `redir_valid` is 0.
- R2: Accepted dispatches get consecutive tags modulo DEPTH, counting from the tag shown on `disp_tag`.
- R3: With DEPTH instructions in flight `disp_ready` is 0, and a dispatch request offered while it is 0 is ignored: the tag is not consumed and the request never retires.
- R4: An instruction retires only after it has finished, and only once every older instruction has retired; retirements appear in dispatch order.
- R5: Two instructions retire in one cycle when the two oldest have both finished cleanly. Slot 1 (bits [1], upper fields) is always younger than slot 0 and is valid only together with slot 0.
- R6: A retiring slot carries the result data last written by a finish port for that tag, together with the destination number and file select (`1` = floating-point) given at dispatch.
- R7: A finish with the exception flag set produces no redirect until that instruction is the oldest in flight. Then `redir_valid` is 1 for exactly one cycle, with `redir_pc` and `redir_tag` taken from that instruction, and the instruction is not retired.
- R8: In the redirect cycle `disp_ready` is 0. Afterwards the buffer is empty, no younger instruction ever retires, and the next dispatch receives the faulting instruction's tag.
- R9: A finish naming a tag with no instruction in flight is ignored. A later instruction dispatched into that slot does not retire until its own finish arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Buffer can accept a dispatch this cycle |
| disp_fp | input | 1 | Destination file select, 1 = floating-point |
| disp_dest | input | RW | Destination register number |
| disp_pc | input | PCW | Program counter of the dispatched instruction |
| disp_tag | output | AW | Tag assigned to the instruction dispatched this cycle |
| fin_valid | input | NF | One finish strobe per execution-unit port |
| fin_tag | input | NF*AW | Tag of the finishing instruction, port p at [p*AW +: AW] |
| fin_data | input | NF*DW | Result, port p at [p*DW +: DW] |
| fin_exc | input | NF | Finishing instruction faulted |
| rt_valid | output | 2 | Retire strobes, bit 0 = oldest |
| rt_fp | output | 2 | File select per retire slot |
| rt_dest | output | 2*RW | Destination number per retire slot |
| rt_data | output | 2*DW | Result per retire slot |
| redir_valid | output | 1 | Precise exception flush and refetch request |
| redir_pc | output | PCW | Program counter of the faulting instruction |
| redir_tag | output | AW | Tag of the faulting instruction |

## Verification
Full buffers of eight instructions are finished under every permutation of the form (k*step + offset) mod 8 with odd step. The finishes come one per cycle and, in a second pass, two per cycle on both ports. This separates true in-order retirement from any shortcut that lets a finished younger entry pass an older one. The fully reversed orders must drain in four dual-retire cycles. A separate sweep places the fault on each of four positions in flight. It shows that older instructions still retire, that exactly one redirect with the right program counter appears, and that the faulting slot is reused afterwards. Overfull dispatch requests and stale finishes to freed slots check that ignored stimulus leaves no trace on the retire stream.

// File: rtl/retire_queue.sv
module retire_queue #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int RW    = 5,
  parameter int NF    = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic              disp_fp,
  input  logic [RW-1:0]     disp_dest,
  input  logic [PCW-1:0]    disp_pc,
  output logic [AW-1:0]     disp_tag,
  input  logic [NF-1:0]     fin_valid,
  input  logic [NF*AW-1:0]  fin_tag,
  input  logic [NF*DW-1:0]  fin_data,
  input  logic [NF-1:0]     fin_exc,
  output logic [1:0]        rt_valid,
  output logic [1:0]        rt_fp,
  output logic [2*RW-1:0]   rt_dest,
  output logic [2*DW-1:0]   rt_data,
  output logic              redir_valid,
  output logic [PCW-1:0]    redir_pc,
  output logic [AW-1:0]     redir_tag
);

  logic [DEPTH-1:0] busy, done, exc, fp;
  logic [RW-1:0]    dest [DEPTH];
  logic [PCW-1:0]   pc   [DEPTH];
  logic [DW-1:0]    res  [DEPTH];
  logic [AW-1:0]    head, tail;
  logic [CW-1:0]    count;

  wire [AW-1:0] head1  = head + 1'b1;
  wire          flush  = busy[head] & done[head] & exc[head];
  wire          r0     = busy[head] & done[head] & ~exc[head];
  wire          r1     = r0 & busy[head1] & done[head1] & ~exc[head1];
  wire          accept = disp_valid & disp_ready;

  assign disp_ready  = (count != CW'(DEPTH)) & ~flush;
  assign disp_tag    = tail;
  assign rt_valid    = {r1, r0};
  assign rt_fp       = {fp[head1], fp[head]};
  assign rt_dest     = {dest[head1], dest[head]};
  assign rt_data     = {res[head1], res[head]};
  assign redir_valid = flush;
  assign redir_pc    = pc[head];
  assign redir_tag   = head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      done  <= '0;
      exc   <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      busy  <= '0;
      tail  <= head;
      count <= '0;
    end else begin
      for (int p = 0; p < NF; p++) begin
        if (fin_valid[p] && busy[fin_tag[p*AW +: AW]]) begin
          done[fin_tag[p*AW +: AW]] <= 1'b1;
          exc[fin_tag[p*AW +: AW]]  <= fin_exc[p];
        end
      end
      if (r0) busy[head]  <= 1'b0;
      if (r1) busy[head1] <= 1'b0;
      if (accept) begin
        busy[tail] <= 1'b1;
        done[tail] <= 1'b0;
        exc[tail]  <= 1'b0;
        tail       <= tail + 1'b1;
      end
      head  <= head + AW'(r0) + AW'(r1);
      count <= count + CW'(accept) - CW'(r0) - CW'(r1);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int p = 0; p < NF; p++)
        if (fin_valid[p] && busy[fin_tag[p*AW +: AW]])
          res[fin_tag[p*AW +: AW]] <= fin_data[p*DW +: DW];
      if (accept) begin
        fp[tail]   <= disp_fp;
        dest[tail] <= disp_dest;
        pc[tail]   <= disp_pc;
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !disp_ready);

  a_r6_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid[0] && !accept) |=> (count < $past(count)));

  a_r7_redirect_single: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  a_r8_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (count == '0 && rt_valid == 2'b00 && disp_tag == $past(redir_tag)));

endmodule

// File: tb/test_retire_queue.sv
module test_retire_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, DW = 16, PCW = 16, RW = 5, NF = 2;
  localparam int AW = 3;
  localparam int NS = 1024;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_fp = 0;
  logic [RW-1:0] disp_dest = '0;
  logic [PCW-1:0] disp_pc = '0;
  logic disp_ready;
  logic [AW-1:0] disp_tag;
  logic [NF-1:0] fin_valid = '0, fin_exc = '0;
  logic [NF*AW-1:0] fin_tag = '0;
  logic [NF*DW-1:0] fin_data = '0;
  logic [1:0] rt_valid, rt_fp;
  logic [2*RW-1:0] rt_dest;
  logic [2*DW-1:0] rt_data;
  logic redir_valid;
  logic [PCW-1:0] redir_pc;
  logic [AW-1:0] redir_tag;

  retire_queue #(.DEPTH(DEPTH), .DW(DW), .PCW(PCW), .RW(RW), .NF(NF)) i_retire_queue (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_fp(disp_fp), .disp_dest(disp_dest), .disp_pc(disp_pc), .disp_tag(disp_tag),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_data(fin_data), .fin_exc(fin_exc),
    .rt_valid(rt_valid), .rt_fp(rt_fp), .rt_dest(rt_dest), .rt_data(rt_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_tag(redir_tag));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int nseq = 0, exp_seq = 0, ret_cnt = 0, pair_cnt = 0, flush_cnt = 0;
  int tail_m = 0;
  bit finished = 0;
  logic [AW-1:0] s_tag [NS];
  bit s_fin [NS];
  bit s_exc [NS];

  function automatic logic [DW-1:0] dat_of(int s); return DW'(16'h5A00 ^ (s * 131)); endfunction
  function automatic logic [PCW-1:0] pc_of(int s); return PCW'(16'h1000 + s * 4); endfunction
  function automatic logic [RW-1:0] dst_of(int s); return RW'(s % 32); endfunction
  function automatic logic fp_of(int s); return s[0] ^ s[3]; endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(rt_valid[1] && !rt_valid[0]), "R5", {30'd0, rt_valid}, 32'd1);
      for (int k = 0; k < 2; k++) begin
        if (rt_valid[k]) begin
          chk(exp_seq < nseq && s_fin[exp_seq] && !s_exc[exp_seq], "R4", exp_seq, nseq);
          chk(rt_data[k*DW +: DW] == dat_of(exp_seq), "R6", rt_data[k*DW +: DW], dat_of(exp_seq));
          chk(rt_dest[k*RW +: RW] == dst_of(exp_seq), "R6", rt_dest[k*RW +: RW], dst_of(exp_seq));
          chk(rt_fp[k] == fp_of(exp_seq), "R6", rt_fp[k], fp_of(exp_seq));
          exp_seq++;
          ret_cnt++;
        end
      end
      if (rt_valid == 2'b11) pair_cnt++;
      if (redir_valid) begin
        chk(exp_seq < nseq && s_exc[exp_seq] && s_fin[exp_seq], "R7", exp_seq, nseq);
        chk(redir_pc == pc_of(exp_seq), "R7", redir_pc, pc_of(exp_seq));
        chk(redir_tag == s_tag[exp_seq], "R7", redir_tag, s_tag[exp_seq]);
        chk(!disp_ready, "R8", disp_ready, 0);
        tail_m = s_tag[exp_seq];
        exp_seq = nseq;
        flush_cnt++;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic dispatch();
    chk(disp_ready, "R3", disp_ready, 1);
    chk(disp_tag == AW'(tail_m), "R2", disp_tag, tail_m);
    s_tag[nseq] = disp_tag;
    s_fin[nseq] = 0;
    s_exc[nseq] = 0;
    disp_valid = 1; disp_pc = pc_of(nseq); disp_dest = dst_of(nseq); disp_fp = fp_of(nseq);
    nseq++;
    tail_m = (tail_m + 1) % DEPTH;
    tick(1);
    disp_valid = 0;
  endtask

  task automatic finish(int sa, bit ea, int sb, bit eb, bit two);
    fin_valid = {two, 1'b1};
    fin_tag = {s_tag[sb], s_tag[sa]};
    fin_data = {dat_of(sb), dat_of(sa)};
    fin_exc = {eb, ea};
    s_fin[sa] = 1; s_exc[sa] = ea;
    if (two) begin s_fin[sb] = 1; s_exc[sb] = eb; end
    tick(1);
    fin_valid = '0; fin_exc = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(disp_ready == 1, "R1", disp_ready, 1);
    chk(disp_tag == 0, "R1", disp_tag, 0);
    chk(rt_valid == 0, "R1", rt_valid, 0);
    chk(redir_valid == 0, "R1", redir_valid, 0);

    // R4 R5 R6: permutation sweep over a full buffer
    for (int mode = 0; mode < 2; mode++)
      for (int step = 1; step < 8; step += 2)
        for (int off = 0; off < 8; off++) begin
          int base, pc0, r0c;
          base = nseq;
          for (int i = 0; i < DEPTH; i++) dispatch();
          chk(disp_ready == 0, "R3", disp_ready, 0);
          pc0 = pair_cnt; r0c = ret_cnt;
          for (int k = 0; k < DEPTH; k += (mode + 1)) begin
            int a, b;
            a = base + (k * step + off) % DEPTH;
            b = base + ((k + 1) * step + off) % DEPTH;
            finish(a, 0, b, 0, mode == 1);
          end
          tick(6);
          chk(exp_seq == nseq, "R4", exp_seq, nseq);
          chk(ret_cnt - r0c == DEPTH, "R4", ret_cnt - r0c, DEPTH);
          if (step == 7 && off == 7)
            chk(pair_cnt - pc0 == 4, "R5", pair_cnt - pc0, 4);
        end

    // R3: request while full is ignored
    begin
      int base, r0c;
      base = nseq;
      for (int i = 0; i < DEPTH; i++) dispatch();
      disp_valid = 1; disp_pc = 16'hBEEF;
      for (int i = 0; i < 3; i++) begin
        chk(disp_ready == 0, "R3", disp_ready, 0);
        tick(1);
      end
      disp_valid = 0;
      chk(disp_tag == AW'(tail_m), "R3", disp_tag, tail_m);
      r0c = ret_cnt;
      for (int i = 0; i < DEPTH; i++) finish(base + i, 0, 0, 0, 0);
      tick(6);
      chk(ret_cnt - r0c == DEPTH, "R3", ret_cnt - r0c, DEPTH);
      chk(disp_ready == 1, "R3", disp_ready, 1);
    end

    // R7 R8 R9: fault position sweep
    for (int e = 0; e < 4; e++) begin
      int base, r0c, f0c, ftag, ns;
      base = nseq;
      for (int i = 0; i < 4; i++) dispatch();
      r0c = ret_cnt; f0c = flush_cnt;
      finish(base + e, 1, 0, 0, 0);
      if (e > 0) chk(redir_valid == 0, "R7", redir_valid, 0);
      for (int i = 3; i >= 0; i--) if (i != e) finish(base + i, 0, 0, 0, 0);
      tick(4);
      chk(flush_cnt - f0c == 1, "R7", flush_cnt - f0c, 1);
      chk(ret_cnt - r0c == e, "R8", ret_cnt - r0c, e);
      chk(disp_ready == 1, "R8", disp_ready, 1);
      ftag = s_tag[base + e];
      chk(disp_tag == AW'(ftag), "R8", disp_tag, ftag);
      // stale finish to the freed slot
      fin_valid = 2'b01; fin_tag = {3'd0, AW'(ftag)}; fin_data = {16'd0, 16'hDEAD}; fin_exc = 0;
      tick(1);
      fin_valid = '0;
      ns = nseq;
      dispatch();
      chk(s_tag[ns] == AW'(ftag), "R8", s_tag[ns], ftag);
      r0c = ret_cnt;
      tick(3);
      chk(ret_cnt == r0c, "R9", ret_cnt - r0c, 0);
      finish(ns, 0, 0, 0, 0);
      tick(2);
      chk(ret_cnt - r0c == 1, "R9", ret_cnt - r0c, 1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule